// File: doc/BRIEF.md
# Virtual Disk Sector Cycle-Steal Loader

This block is the logic-side half of a disk adapter whose media is a file image held on an external PC. The host CPU asks for one sector by giving a drive number and the core address of its buffer. If the drive number names the single virtual drive, the block passes the request on to the PC with a one-cycle pulse. It then idles until the PC signals that the sector is ready. That completion signal moves the block into the transfer at the next clock edge, whatever the host is doing, so no host reset is needed to wake it.

During the transfer the block reads the sector out of the PC-side word store, one 16-bit word at a time and in index order. Each word goes into host core through a cycle-steal request/acknowledge handshake, one word per stolen cycle. The core address steps by one for each word. When the last of the sector's words has been acknowledged, the block sets its done status bit and raises an interrupt request.

A request for any other drive number is answered with a not-ready code. A request for the virtual drive that arrives while a request or transfer is still open is answered with a busy code and changes nothing.

Top module: `vsl_loader`

## Requirements
- R1: After reset, `cs_req`, `pc_req`, `busy`, `dsw_done`, `irq` and `stat_valid` are all low.
- R2: A request (`req_valid` high for one cycle) whose `req_drive` differs from `DRIVE_ID` (default 4) is answered in the next cycle by `stat_valid`=1 with `stat_code`=1 (not ready). This has priority over the busy code. It produces no `pc_req` and leaves any transfer in progress unchanged.
- R3: A request for `DRIVE_ID` while the block is idle is answered in the next cycle by `stat_valid`=1 with `stat_code`=0 (accepted). In that same cycle `pc_req` is high for exactly one cycle, `busy` goes high, and `dsw_done` and `irq` are cleared.
- R4: After accepting a request, the block raises no `cs_req` until `pc_done` is sampled high. It then raises `cs_req` in the very next cycle. A `pc_done` seen while idle or during a transfer has no effect.
- R5: While `cs_req` is high and `cs_ack` is low, `cs_addr`, `cs_data` and `cs_req` stay unchanged.
- R6: The k-th word written (k from 0) is presented with `pc_rd_idx`=k, `cs_data` equal to the PC store word k, and `cs_addr` equal to the base address plus k.
- R7: Exactly `WORDS` (default 320) acknowledged writes happen per sector. In the cycle after the last acknowledge, `cs_req` and `busy` are low and `dsw_done` and `irq` are high. Both stay high until the next accepted request.
- R8: A request for `DRIVE_ID` while `busy` is high is answered in the next cycle by `stat_code`=2 (busy). It produces no `pc_req`, and the open transfer keeps its base address and word order.
- R9: The core address is `AW` bits wide (default 16) and wraps modulo 2^AW when a sector crosses the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host sector-read request strobe |
| req_drive | input | DRVW (3) | Drive number of the request |
| req_addr | input | AW (16) | Core buffer start address |
| stat_valid | output | 1 | Response code valid, one cycle |
| stat_code | output | 2 | 0 accepted, 1 not ready, 2 busy |
| busy | output | 1 | Request or transfer open |
| pc_req | output | 1 | One-cycle pulse asking the PC for the sector |
| pc_done | input | 1 | Operation-complete status from the PC |
| pc_rd_idx | output | IW (9) | Word index read from the PC-side store |
| pc_rd_data | input | DW (16) | Word at `pc_rd_idx` |
| cs_req | output | 1 | Cycle-steal request |
| cs_addr | output | AW (16) | Core address of the current word |
| cs_data | output | DW (16) | Data of the current word |
| cs_ack | input | 1 | Cycle-steal grant; the word is taken at this edge |
| dsw_done | output | 1 | Done bit of the device status word |
| irq | output | 1 | Interrupt request to the host |

## Verification
Full sectors are moved with several acknowledge rhythms: immediate grants, fixed stalls, and stalls that vary by word index. These separate a design that steps on the grant from one that steps on the request or that drifts while waiting. Base addresses at zero, mid-range and just below the top of the address space separate word-granular stepping and wrap-around from byte stepping or saturation. Every drive number is swept while idle and again while a transfer is open, which separates the not-ready, busy and accepted codes and their priority. Stray completion pulses while idle and mid-transfer, and the long wait before completion, show whether the FSM reacts only to a completion it is waiting for.

// File: rtl/vsl_pkg.sv
package vsl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_XFER = 2'd2
   } xfer_st_t;

   typedef enum logic [1:0] {
      RSP_OK     = 2'd0,
      RSP_NOTRDY = 2'd1,
      RSP_BUSY   = 2'd2
   } rsp_t;
endpackage

// File: rtl/vsl_req_decode.sv
module vsl_req_decode
   import vsl_pkg::*;
#(
   parameter int DRVW     = 3,
   parameter int DRIVE_ID = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [DRVW-1:0] req_drive,
   input  logic            busy,
   output logic            start,
   output logic            stat_valid,
   output logic [1:0]      stat_code
);
   localparam logic [DRVW-1:0] MY_DRIVE = DRVW'(DRIVE_ID);

   generate
      if (DRIVE_ID < 0 || DRIVE_ID >= (1 << DRVW)) begin : g_bad_id
         $error("DRIVE_ID does not fit in DRVW bits");
      end
   endgenerate

   logic match;
   assign match = (req_drive == MY_DRIVE);
   assign start = req_valid && match && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_valid <= 1'b0;
         stat_code  <= RSP_OK;
      end else begin
         stat_valid <= req_valid;
         if (req_valid) begin
            if (!match)     stat_code <= RSP_NOTRDY;
            else if (busy)  stat_code <= RSP_BUSY;
            else            stat_code <= RSP_OK;
         end
      end
   end

   a_r2_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !match |=> stat_valid && stat_code == RSP_NOTRDY);
   a_r8_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && match && busy |=> stat_valid && stat_code == RSP_BUSY);
endmodule

// File: rtl/vsl_xfer_fsm.sv
module vsl_xfer_fsm
   import vsl_pkg::*;
#(
   parameter int WORDS = 320,
   parameter int AW    = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base_addr,
   input  logic          pc_done,
   input  logic          cs_ack,
   output logic          pc_req,
   output logic          cs_req,
   output logic [AW-1:0] cs_addr,
   output logic [((WORDS > 1) ? $clog2(WORDS) : 1)-1:0] rd_idx,
   output logic          busy,
   output logic          fin
);
   localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int CW = $clog2(WORDS + 1);

   generate
      if (WORDS < 1) begin : g_bad_words
         $error("WORDS must be at least 1");
      end
   endgenerate

   xfer_st_t      st;
   logic [CW-1:0] cnt;
   logic          take;

   assign cs_req = (st == ST_XFER);
   assign busy   = (st != ST_IDLE);
   assign take   = cs_req && cs_ack;
   assign fin    = take && (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         cs_addr <= '0;
         rd_idx  <= '0;
         pc_req  <= 1'b0;
      end else begin
         pc_req <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st      <= ST_WAIT;
                  cs_addr <= base_addr;
                  pc_req  <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (pc_done) begin
                  st     <= ST_XFER;
                  cnt    <= CW'(WORDS);
                  rd_idx <= '0;
               end
            end
            ST_XFER: begin
               if (take) begin
                  cs_addr <= cs_addr + 1'b1;
                  rd_idx  <= rd_idx + 1'b1;
                  cnt     <= cnt - 1'b1;
                  if (cnt == CW'(1)) st <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r4_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_WAIT && !pc_done |=> !cs_req);
   a_r4_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_WAIT && pc_done |=> cs_req);
   a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      cs_req && !cs_ack |=> cs_req && $stable(cs_addr) && $stable(rd_idx));
   a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      take && !fin |=> cs_addr == AW'($past(cs_addr) + 1'b1));
   a_r7_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !cs_req && !busy);
   a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pc_req |=> !pc_req);
endmodule

// File: rtl/vsl_status.sv
module vsl_status #(
   parameter bit IRQ_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fin,
   output logic dsw_done,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)      dsw_done <= 1'b0;
      else if (start)  dsw_done <= 1'b0;
      else if (fin)    dsw_done <= 1'b1;
   end

   generate
      if (IRQ_LEVEL) begin : g_irq_level
         always_ff @(posedge clk) begin
            if (!rst_n)      irq <= 1'b0;
            else if (start)  irq <= 1'b0;
            else if (fin)    irq <= 1'b1;
         end
      end else begin : g_irq_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= fin;
         end
      end
   endgenerate

   a_r7_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> dsw_done);
   a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> dsw_done);
   a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !dsw_done);
endmodule

// File: rtl/vsl_loader.sv
module vsl_loader
   import vsl_pkg::*;
#(
   parameter int WORDS     = 320,
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int DRVW      = 3,
   parameter int DRIVE_ID  = 4,
   parameter bit IRQ_LEVEL = 1'b1,
   localparam int IW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [DRVW-1:0] req_drive,
   input  logic [AW-1:0]   req_addr,
   output logic            stat_valid,
   output logic [1:0]      stat_code,
   output logic            busy,
   output logic            pc_req,
   input  logic            pc_done,
   output logic [IW-1:0]   pc_rd_idx,
   input  logic [DW-1:0]   pc_rd_data,
   output logic            cs_req,
   output logic [AW-1:0]   cs_addr,
   output logic [DW-1:0]   cs_data,
   input  logic            cs_ack,
   output logic            dsw_done,
   output logic            irq
);
   logic start;
   logic fin;

   vsl_req_decode #(.DRVW(DRVW), .DRIVE_ID(DRIVE_ID)) u_dec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
      .busy(busy), .start(start), .stat_valid(stat_valid), .stat_code(stat_code)
   );

   vsl_xfer_fsm #(.WORDS(WORDS), .AW(AW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(req_addr),
      .pc_done(pc_done), .cs_ack(cs_ack), .pc_req(pc_req), .cs_req(cs_req),
      .cs_addr(cs_addr), .rd_idx(pc_rd_idx), .busy(busy), .fin(fin)
   );

   vsl_status #(.IRQ_LEVEL(IRQ_LEVEL)) u_st (
      .clk(clk), .rst_n(rst_n), .start(start), .fin(fin),
      .dsw_done(dsw_done), .irq(irq)
   );

   assign cs_data = pc_rd_data;

   a_r2_no_fetch_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_drive != DRVW'(DRIVE_ID) |=> !pc_req);
   a_r8_no_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && busy |=> !pc_req);
endmodule

// File: tb/vsl_loader_tb.sv
module vsl_loader_tb_top;
   localparam int WORDS = 320;
   localparam int DW = 16;
   localparam int AW = 16;
   localparam int DRVW = 3;
   localparam int IW = $clog2(WORDS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [DRVW-1:0] req_drive = '0;
   logic [AW-1:0] req_addr = '0;
   logic stat_valid, busy, pc_req, cs_req, dsw_done, irq;
   logic [1:0] stat_code;
   logic pc_done = 1'b0;
   logic cs_ack = 1'b0;
   logic [IW-1:0] pc_rd_idx;
   logic [DW-1:0] pc_rd_data;
   logic [AW-1:0] cs_addr;
   logic [DW-1:0] cs_data;
   logic [DW-1:0] seed = 16'h0;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [DW-1:0] s, input int k);
      return s ^ DW'(k * 37) ^ DW'(k << 8);
   endfunction

   assign pc_rd_data = pat(seed, int'(pc_rd_idx));

   vsl_loader dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
      .req_addr(req_addr), .stat_valid(stat_valid), .stat_code(stat_code),
      .busy(busy), .pc_req(pc_req), .pc_done(pc_done), .pc_rd_idx(pc_rd_idx),
      .pc_rd_data(pc_rd_data), .cs_req(cs_req), .cs_addr(cs_addr),
      .cs_data(cs_data), .cs_ack(cs_ack), .dsw_done(dsw_done), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // one request at negedge; response visible at next negedge
   task automatic send_req(input int drv, input logic [AW-1:0] a);
      req_valid = 1'b1;
      req_drive = DRVW'(drv);
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // full sector; stall pattern: mode 0 none, 1 fixed 2, 2 varies by k
   task automatic run_sector(input logic [AW-1:0] base, input logic [DW-1:0] s,
                             input int mode, input bool_mid);
      int werr;
      int herr;
      int n;
      seed = s;
      send_req(4, base);
      chk(stat_valid && stat_code == 2'd0, "R3 accept code", stat_code, 0);
      chk(pc_req && busy && !dsw_done && !irq, "R3 pc_req/busy/clear",
          {pc_req, busy, dsw_done, irq}, 4'b1100);
      @(negedge clk);
      chk(!pc_req, "R3 pc_req one cycle", pc_req, 0);
      // long wait, stray requests while waiting
      herr = 0;
      for (int i = 0; i < 20; i++) begin
         if (cs_req) herr++;
         @(negedge clk);
      end
      chk(herr == 0, "R4 no write before done", herr, 0);
      if (bool_mid) begin
         for (int d = 0; d < 8; d++) begin
            send_req(d, ~base);
            chk(stat_valid && stat_code == ((d == 4) ? 2'd2 : 2'd1),
                (d == 4) ? "R8 busy code" : "R2 not-ready over busy",
                stat_code, (d == 4) ? 2 : 1);
            chk(!pc_req && !cs_req, "R8 no fetch while busy", pc_req, 0);
         end
      end
      pc_done = 1'b1;
      @(negedge clk);
      pc_done = 1'b0;
      chk(cs_req && cs_addr == base, "R4 prompt start / R6 base", cs_addr, base);
      werr = 0;
      herr = 0;
      n = 0;
      for (int k = 0; k < WORDS; k++) begin
         int st;
         logic [AW-1:0] ea;
         ea = AW'(base + AW'(k));
         st = (mode == 0) ? 0 : (mode == 1) ? 2 : (k % 4);
         for (int w = 0; w < st; w++) begin
            @(negedge clk);
            if (!cs_req || cs_addr != ea || cs_data != pat(s, k)) herr++;
            if (bool_mid && w == 0 && k == 100) begin
               pc_done = 1'b1;
            end else begin
               pc_done = 1'b0;
            end
         end
         pc_done = 1'b0;
         if (!cs_req || cs_addr != ea || cs_data != pat(s, k) || int'(pc_rd_idx) != k) begin
            if (werr == 0)
               $display("FAIL R6 word %0d actual addr=%0h data=%0h expected addr=%0h data=%0h",
                        k, cs_addr, cs_data, ea, pat(s, k));
            werr++;
         end
         cs_ack = 1'b1;
         n++;
         @(negedge clk);
         cs_ack = 1'b0;
      end
      total++;
      if (werr != 0) bad++;
      chk(herr == 0, "R5 hold while stalled", herr, 0);
      chk(n == WORDS && !cs_req && !busy, "R7 exact count, stops", {cs_req, busy}, 0);
      chk(dsw_done && irq, "R7 done and irq", {dsw_done, irq}, 2'b11);
      repeat (3) @(negedge clk);
      chk(dsw_done && irq && !cs_req, "R7 done held", {dsw_done, irq, cs_req}, 3'b110);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!cs_req && !pc_req && !busy && !dsw_done && !irq && !stat_valid,
          "R1 reset state", {cs_req, pc_req, busy, dsw_done, irq, stat_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cs_req && !busy && !stat_valid, "R1 after reset release", busy, 0);

      // idle sweep of foreign drives
      for (int d = 0; d < 8; d++) begin
         if (d == 4) continue;
         send_req(d, 16'h1234);
         chk(stat_valid && stat_code == 2'd1, "R2 not ready", stat_code, 1);
         chk(!pc_req && !busy, "R2 no fetch", {pc_req, busy}, 0);
         @(negedge clk);
         chk(!stat_valid, "R2 code one cycle", stat_valid, 0);
      end

      // stray completion while idle
      pc_done = 1'b1;
      @(negedge clk);
      pc_done = 1'b0;
      @(negedge clk);
      chk(!cs_req && !busy, "R4 stray done ignored when idle", {cs_req, busy}, 0);

      run_sector(16'h0000, 16'hA5C3, 0, 1'b0);
      run_sector(16'h4000, 16'h1F0E, 1, 1'b1);
      run_sector(16'hFF00, 16'h5803, 2, 1'b0);   // R9 wrap at top
      run_sector(16'h8ABC, 16'h0000, 2, 1'b1);
      finish_run();
   end
endmodule